// File: doc/BRIEF.md
# PRP list fetch manager

This block serves follow-up requests for NVMe physical region page (PRP) entries. The initial set of entries for a command already sits in the ping half of the command's buffer slot. When the application needs more, it sends a 128-bit fetch-information word on an AXI4-Stream request channel. The block works out how many 64-bit entries to read from host memory and issues one host-to-card DMA request for them. It writes each returned entry into the half of the slot that the request word did not name. When the read finishes, it returns a 16-bit fill descriptor together with an updated fetch-information word. The application uses that word for its next request.

The controller is a six-state machine. **IDLE** accepts a request (IDLE→PLAN on the request handshake). **PLAN** latches the entry count and whether a list-chain pointer is expected; it moves to ISSUE when the count is nonzero and to FINISH when it is zero. **ISSUE** holds the DMA request until it is accepted (ISSUE→RECV). **RECV** stores each returned entry, checks it and captures the chain pointer (RECV→FINISH on the last entry). **FINISH** registers the updated word (FINISH→RESPOND). **RESPOND** holds the fill descriptor until it is taken (RESPOND→IDLE). Only one fetch is in flight at a time.

Fetch-information word layout:

| Bits | Field |
|------|-------|
| [31:0] | remaining transfer size in bytes |
| [92:32] | host address bits 63:3 of the next entry to fetch |
| [93] | unused, driven to zero |
| [94] | list format; 0 selects PRP |
| [106:95] | buffer index |
| [107] | half select; 0 is ping, 1 is pong |
| [117:108] | descriptors left in the current PRP list |
| [123:118] | error code |
| [127:124] | number of valid data entries |

Below, N is the number of entries per slot half (parameter, default 8), need is ceil(size/4096), and cnt is the number of entries fetched.

Top module: `prp_fetch_mgr`

## Requirements
- R1: After reset the block is in IDLE with req_tready = 1, and fill_tvalid, dma_req_valid and mem_we are all 0.
- R2: req_tready is 0 from the cycle after a request handshake until the cycle after the fill handshake; no second request is accepted in between.
- R3: The fill descriptor carries the buffer index in bits [11:0] and the target half in bit [12], and has bits [15:13] at zero. The target half is the inverse of request bit [107], so successive fetches alternate between ping and pong.
- R4: cnt = min(N, descriptors left, need). The DMA request carries address = request bits [92:32] shifted left by 3, and count = cnt.
- R5: Entry k (from 0) is written with mem_wdata equal to the returned entry, at mem_addr = BASE + ((index*2 + target half)*N + k)*8, in arrival order.
- R6: If descriptors left > N and need >= N, the last of the N fetched entries is a chain pointer. It is not counted as data; the output host address is pointer bits [63:3], and the output descriptors-left field is LIST_ENT (default 512).
- R7: With D data entries, the output size is size - D*4096, saturating at 0. A zero output size marks the last PRP of the transfer.
- R8: Without a chain, the output host address is the input address + cnt and the output descriptors-left field is the input value - cnt.
- R9: The output valid-entries field [127:124] equals D. The index and format bits are copied from the request, and bit [93] is 0.
- R10: The output error code is 1 if any data entry has a nonzero low 12 bits, or if the chain pointer has nonzero bits [1:0]. Otherwise it is 0, whatever error code the request carried.
- R11: When cnt = 0, no DMA request is issued, and the fill descriptor is still returned with valid entries 0.
- R12: While fill_tvalid is 1 and fill_tready is 0, fill_tdata and info_tdata hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| req_tvalid | input | 1 | fetch request valid |
| req_tready | output | 1 | fetch request ready (high only in IDLE) |
| req_tdata | input | 128 | fetch-information word |
| dma_req_valid | output | 1 | DMA read request valid |
| dma_req_ready | input | 1 | DMA read request accepted |
| dma_req_addr | output | 64 | host byte address of the first entry |
| dma_req_count | output | $clog2(N+1) | number of 64-bit entries to read |
| dma_rsp_valid | input | 1 | returned entry valid (always accepted in RECV) |
| dma_rsp_data | input | 64 | returned PRP entry |
| mem_we | output | 1 | buffer memory write strobe |
| mem_addr | output | AW | buffer memory byte address |
| mem_wdata | output | 64 | buffer memory write data |
| fill_tvalid | output | 1 | fill descriptor valid |
| fill_tready | input | 1 | fill descriptor ready |
| fill_tdata | output | 16 | fill descriptor |
| info_tdata | output | 128 | updated fetch-information word, valid with fill_tvalid |

## Verification
The bench targets the chain-pointer boundary, where need equals N exactly and the list continues. A design that mixed up the two limits would count the pointer as data, or take its next address from a data entry. It also checks the check on the pointer against the check on data entries, using a pointer that is qword aligned but not page aligned. An RTL that applied the data-entry rule to the pointer would raise a false error. Other cases are a size that is not a multiple of 4096, where the subtraction must saturate, the highest buffer index, a zero-entry request that must skip the DMA, and a request that arrives while a fetch is busy. A stuck ping/pong bit, a missing busy hold-off or a descriptor that changes under back-pressure each shows up as a mismatch against the bench's cycle-by-cycle model.

// File: rtl/prp_fm_pkg.sv
package prp_fm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_ISSUE,
        ST_RECV,
        ST_FINISH,
        ST_RESPOND
    } fm_state_e;

    typedef struct packed {
        logic [3:0]  valid_ent;
        logic [5:0]  err;
        logic [9:0]  desc_left;
        logic        half;
        logic [11:0] idx;
        logic        fmt;
        logic        spare;
        logic [60:0] haddr;
        logic [31:0] size;
    } fetch_info_t;

    typedef struct packed {
        logic [2:0]  zero;
        logic        half;
        logic [11:0] idx;
    } fill_desc_t;

    localparam int unsigned PAGE_SHIFT     = 12;
    localparam logic [5:0]  ERR_BAD_OFFSET = 6'd1;

endpackage

// File: rtl/prp_fetch_plan.sv
module prp_fetch_plan #(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 4
) (
    input  logic [31:0]   size_left,
    input  logic [9:0]    desc_left,
    output logic [CW-1:0] cnt,
    output logic          chain,
    output logic [CW-1:0] data_cnt
);
    logic [32:0] rounded;
    logic [20:0] need;
    logic [20:0] cap_w;
    logic [20:0] desc_w;
    logic [20:0] lim_a;
    logic [20:0] lim_b;

    assign rounded = {1'b0, size_left} + 33'd4095;
    assign need    = rounded[32:12];
    assign cap_w   = 21'(N);
    assign desc_w  = {11'd0, desc_left};

    always_comb begin
        lim_a    = (desc_w < cap_w) ? desc_w : cap_w;
        lim_b    = (need < lim_a) ? need : lim_a;
        cnt      = CW'(lim_b);
        chain    = (desc_w > cap_w) && (need >= cap_w);
        data_cnt = chain ? CW'(N - 1) : CW'(lim_b);
    end
endmodule

// File: rtl/prp_entry_check.sv
module prp_entry_check (
    input  logic [63:0] entry,
    input  logic        is_ptr,
    output logic        bad
);
    always_comb begin
        if (is_ptr) bad = (entry[1:0] != 2'b00);
        else        bad = (entry[11:0] != 12'h000);
    end
endmodule

// File: rtl/prp_slot_addr.sv
module prp_slot_addr #(
    parameter int unsigned N    = 8,
    parameter int unsigned CW   = 4,
    parameter int unsigned AW   = 32,
    parameter logic [31:0] BASE = 32'h4000_0000
) (
    input  logic [11:0]   idx,
    input  logic          half,
    input  logic [CW-1:0] beat,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] slot_num;
    logic [AW-1:0] entry_num;

    assign slot_num  = AW'({idx, half});
    assign entry_num = (slot_num * AW'(N)) + AW'(beat);
    assign addr      = AW'(BASE) + (entry_num << 3);
endmodule

// File: rtl/prp_info_update.sv
module prp_info_update
    import prp_fm_pkg::*;
#(
    parameter int unsigned CW       = 4,
    parameter int unsigned LIST_ENT = 512
) (
    input  fetch_info_t   req,
    input  logic [CW-1:0] cnt,
    input  logic          chain,
    input  logic [CW-1:0] data_cnt,
    input  logic [60:0]   ptr_addr,
    input  logic          bad,
    output fetch_info_t   upd
);
    logic [32:0] dec;
    logic [32:0] size_w;

    assign dec    = 33'(data_cnt) << PAGE_SHIFT;
    assign size_w = {1'b0, req.size};

    always_comb begin
        upd           = '0;
        upd.size      = (size_w >= dec) ? 32'(size_w - dec) : 32'd0;
        upd.haddr     = chain ? ptr_addr : (req.haddr + 61'(cnt));
        upd.desc_left = chain ? 10'(LIST_ENT) : (req.desc_left - 10'(cnt));
        upd.fmt       = req.fmt;
        upd.idx       = req.idx;
        upd.half      = ~req.half;
        upd.err       = bad ? ERR_BAD_OFFSET : 6'd0;
        upd.valid_ent = 4'(data_cnt);
        upd.spare     = 1'b0;
    end
endmodule

// File: rtl/prp_fetch_mgr.sv
module prp_fetch_mgr
    import prp_fm_pkg::*;
#(
    parameter int unsigned N        = 8,
    parameter int unsigned AW       = 32,
    parameter logic [31:0] BASE     = 32'h4000_0000,
    parameter int unsigned LIST_ENT = 512,
    localparam int unsigned CW      = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_tvalid,
    output logic          req_tready,
    input  logic [127:0]  req_tdata,
    output logic          dma_req_valid,
    input  logic          dma_req_ready,
    output logic [63:0]   dma_req_addr,
    output logic [CW-1:0] dma_req_count,
    input  logic          dma_rsp_valid,
    input  logic [63:0]   dma_rsp_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [63:0]   mem_wdata,
    output logic          fill_tvalid,
    input  logic          fill_tready,
    output logic [15:0]   fill_tdata,
    output logic [127:0]  info_tdata
);
    fm_state_e     state_q, state_d;
    fetch_info_t   req_q;
    fetch_info_t   info_q;
    fetch_info_t   upd;
    fill_desc_t    fill_d;

    logic [CW-1:0] cnt_q, dcnt_q, beat_q;
    logic          chain_q, err_q;
    logic [63:0]   ptr_q;

    logic [CW-1:0] plan_cnt, plan_dcnt;
    logic          plan_chain;
    logic          last_beat, is_ptr, entry_bad;
    logic          req_hs, fill_hs;
    logic          unused_fields;

    assign req_hs    = req_tvalid && req_tready;
    assign fill_hs   = fill_tvalid && fill_tready;
    assign last_beat = (beat_q == (cnt_q - CW'(1)));
    assign is_ptr    = chain_q && last_beat;

    prp_fetch_plan #(.N(N), .CW(CW)) u_plan (
        .size_left (req_q.size),
        .desc_left (req_q.desc_left),
        .cnt       (plan_cnt),
        .chain     (plan_chain),
        .data_cnt  (plan_dcnt)
    );

    prp_entry_check u_check (
        .entry  (dma_rsp_data),
        .is_ptr (is_ptr),
        .bad    (entry_bad)
    );

    prp_slot_addr #(.N(N), .CW(CW), .AW(AW), .BASE(BASE)) u_addr (
        .idx  (req_q.idx),
        .half (~req_q.half),
        .beat (beat_q),
        .addr (mem_addr)
    );

    prp_info_update #(.CW(CW), .LIST_ENT(LIST_ENT)) u_upd (
        .req      (req_q),
        .cnt      (cnt_q),
        .chain    (chain_q),
        .data_cnt (dcnt_q),
        .ptr_addr (ptr_q[63:3]),
        .bad      (err_q),
        .upd      (upd)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_hs) state_d = ST_PLAN;
            ST_PLAN:    state_d = (plan_cnt != '0) ? ST_ISSUE : ST_FINISH;
            ST_ISSUE:   if (dma_req_ready) state_d = ST_RECV;
            ST_RECV:    if (dma_rsp_valid && last_beat) state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_RESPOND;
            ST_RESPOND: if (fill_hs) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= '0;
            info_q  <= '0;
            cnt_q   <= '0;
            dcnt_q  <= '0;
            beat_q  <= '0;
            chain_q <= 1'b0;
            err_q   <= 1'b0;
            ptr_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_hs) req_q <= fetch_info_t'(req_tdata);
                end
                ST_PLAN: begin
                    cnt_q   <= plan_cnt;
                    dcnt_q  <= plan_dcnt;
                    chain_q <= plan_chain;
                    beat_q  <= '0;
                    err_q   <= 1'b0;
                    ptr_q   <= '0;
                end
                ST_RECV: begin
                    if (dma_rsp_valid) begin
                        beat_q <= beat_q + CW'(1);
                        err_q  <= err_q | entry_bad;
                        if (is_ptr) ptr_q <= dma_rsp_data;
                    end
                end
                ST_FINISH: info_q <= upd;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_tready    = 1'b0;
        dma_req_valid = 1'b0;
        mem_we        = 1'b0;
        fill_tvalid   = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_tready    = 1'b1;
            ST_ISSUE:   dma_req_valid = 1'b1;
            ST_RECV:    mem_we        = dma_rsp_valid;
            ST_RESPOND: fill_tvalid   = 1'b1;
            default: ;
        endcase
    end

    assign fill_d.zero    = 3'b000;
    assign fill_d.half    = info_q.half;
    assign fill_d.idx     = info_q.idx;
    assign fill_tdata     = fill_d;
    assign info_tdata     = info_q;
    assign dma_req_addr   = {req_q.haddr, 3'b000};
    assign dma_req_count  = cnt_q;
    assign mem_wdata      = dma_rsp_data;
    assign unused_fields  = ^{req_q.err, req_q.spare, req_q.valid_ent, ptr_q[2:0]};
endmodule

// File: rtl/prp_fetch_mgr_chk.sv
module prp_fetch_mgr_chk #(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_tvalid,
    input logic          req_tready,
    input logic [127:0]  req_tdata,
    input logic          dma_req_valid,
    input logic          dma_req_ready,
    input logic [63:0]   dma_req_addr,
    input logic [CW-1:0] dma_req_count,
    input logic          mem_we,
    input logic          fill_tvalid,
    input logic          fill_tready,
    input logic [15:0]   fill_tdata,
    input logic [127:0]  info_tdata
);
    logic seen_half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        seen_half <= 1'b0;
        else if (req_tvalid && req_tready) seen_half <= req_tdata[107];
    end

    a_r2_busy_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_tvalid || dma_req_valid || mem_we) |-> !req_tready);

    a_r3_half_flips: assert property (@(posedge clk) disable iff (!rst_n)
        fill_tvalid |-> (fill_tdata[12] == ~seen_half));

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fill_tvalid |-> (fill_tdata[15:13] == 3'b000));

    a_r4_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_valid && !dma_req_ready) |=> (dma_req_valid && $stable(dma_req_addr) && $stable(dma_req_count)));

    a_r9_valid_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_tvalid |-> (info_tdata[127:124] <= 4'(N)));

    a_r11_no_empty_dma: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_valid |-> (dma_req_count != '0));

    a_r12_fill_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_tvalid && !fill_tready) |=> (fill_tvalid && $stable(fill_tdata) && $stable(info_tdata)));
endmodule

bind prp_fetch_mgr prp_fetch_mgr_chk #(.N(N), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_tvalid    (req_tvalid),
    .req_tready    (req_tready),
    .req_tdata     (req_tdata),
    .dma_req_valid (dma_req_valid),
    .dma_req_ready (dma_req_ready),
    .dma_req_addr  (dma_req_addr),
    .dma_req_count (dma_req_count),
    .mem_we        (mem_we),
    .fill_tvalid   (fill_tvalid),
    .fill_tready   (fill_tready),
    .fill_tdata    (fill_tdata),
    .info_tdata    (info_tdata)
);

// File: tb/prp_fetch_mgr_test.sv
module prp_fetch_mgr_test;
    localparam int unsigned N  = 8;
    localparam int unsigned CW = $clog2(N + 1);
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_tvalid = 1'b0;
    logic          req_tready;
    logic [127:0]  req_tdata = '0;
    logic          dma_req_valid;
    logic          dma_req_ready = 1'b0;
    logic [63:0]   dma_req_addr;
    logic [CW-1:0] dma_req_count;
    logic          dma_rsp_valid = 1'b0;
    logic [63:0]   dma_rsp_data = '0;
    logic          mem_we;
    logic [31:0]   mem_addr;
    logic [63:0]   mem_wdata;
    logic          fill_tvalid;
    logic          fill_tready = 1'b0;
    logic [15:0]   fill_tdata;
    logic [127:0]  info_tdata;

    always #5 clk = ~clk;

    prp_fetch_mgr uut (
        .clk(clk), .rst_n(rst_n),
        .req_tvalid(req_tvalid), .req_tready(req_tready), .req_tdata(req_tdata),
        .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
        .dma_req_addr(dma_req_addr), .dma_req_count(dma_req_count),
        .dma_rsp_valid(dma_rsp_valid), .dma_rsp_data(dma_rsp_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .fill_tvalid(fill_tvalid), .fill_tready(fill_tready),
        .fill_tdata(fill_tdata), .info_tdata(info_tdata)
    );

    int checks = 0;
    int failures = 0;

    logic [63:0]  host_ent [16];
    logic [31:0]  wr_addr_q [$];
    logic [63:0]  wr_data_q [$];
    int           exp_cnt = 0;
    logic [63:0]  exp_dma_addr = '0;
    int           dma_seen = 0;
    bit           busy = 1'b0;
    bit           prev_fv = 1'b0;
    bit           prev_fr = 1'b0;
    logic [15:0]  prev_fill = '0;
    logic [127:0] prev_info = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // model of the busy window, driven from port handshakes only
    always @(posedge clk) begin
        if (!rst_n) busy <= 1'b0;
        else if (req_tvalid && req_tready) busy <= 1'b1;
        else if (fill_tvalid && fill_tready) busy <= 1'b0;
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(req_tready == !busy, "R2", "req_tready vs busy", 128'(req_tready), 128'(!busy));
            if (mem_we) begin
                if (wr_addr_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected write", 128'(mem_addr), 128'(0));
                end else begin
                    logic [31:0] ea;
                    logic [63:0] ed;
                    ea = wr_addr_q.pop_front();
                    ed = wr_data_q.pop_front();
                    chk(mem_addr == ea, "R5", "write address", 128'(mem_addr), 128'(ea));
                    chk(mem_wdata == ed, "R5", "write data", 128'(mem_wdata), 128'(ed));
                end
            end
            if (dma_req_valid && exp_cnt == 0)
                chk(1'b0, "R11", "DMA request on empty fetch", 128'(dma_req_count), 128'(0));
            if (prev_fv && !prev_fr) begin
                chk(fill_tvalid, "R12", "fill dropped under stall", 128'(fill_tvalid), 128'(1));
                chk(fill_tdata == prev_fill, "R12", "fill changed under stall", 128'(fill_tdata), 128'(prev_fill));
                chk(info_tdata == prev_info, "R12", "info changed under stall", info_tdata, prev_info);
            end
            prev_fv   = fill_tvalid;
            prev_fr   = fill_tready;
            prev_fill = fill_tdata;
            prev_info = info_tdata;
        end
    end

    // DMA responder
    initial begin
        forever begin
            @(negedge clk);
            if (dma_req_valid) begin
                chk(dma_req_addr == exp_dma_addr, "R4", "DMA address", 128'(dma_req_addr), 128'(exp_dma_addr));
                chk(int'(dma_req_count) == exp_cnt, "R4", "DMA count", 128'(dma_req_count), 128'(exp_cnt));
                dma_seen++;
                begin
                    int n;
                    n = int'(dma_req_count);
                    @(negedge clk);
                    dma_req_ready = 1'b1;
                    @(negedge clk);
                    dma_req_ready = 1'b0;
                    for (int k = 0; k < n; k++) begin
                        if (k % 2 == 1) begin
                            dma_rsp_valid = 1'b0;
                            @(negedge clk);
                        end
                        dma_rsp_valid = 1'b1;
                        dma_rsp_data  = host_ent[k];
                        @(negedge clk);
                    end
                    dma_rsp_valid = 1'b0;
                end
            end
        end
    end

    task automatic run_txn(input string name, input logic [31:0] size, input logic [60:0] haddr,
                           input logic [9:0] desc, input logic [11:0] idx, input bit half,
                           input logic [5:0] err_in, input int stall, input bit poke);
        longint need, cnt, dcnt, sz_new;
        bit chain, bad;
        logic [127:0] w, e;
        logic [15:0] ef;
        int seen0;
        need  = (longint'(size) + 4095) / 4096;
        cnt   = need;
        if (longint'(desc) < cnt) cnt = longint'(desc);
        if (longint'(N) < cnt) cnt = longint'(N);
        chain = (desc > 10'(N)) && (need >= longint'(N));
        dcnt  = chain ? longint'(N) - 1 : cnt;
        bad   = 1'b0;
        for (int k = 0; k < int'(cnt); k++) begin
            wr_addr_q.push_back(BASE + 32'(((longint'(idx) * 2 + longint'(!half)) * N + k) * 8));
            wr_data_q.push_back(host_ent[k]);
            if (chain && k == int'(cnt) - 1) bad |= (host_ent[k][1:0] != 2'b00);
            else                             bad |= (host_ent[k][11:0] != 12'h000);
        end
        sz_new = (longint'(size) >= dcnt * 4096) ? longint'(size) - dcnt * 4096 : 0;
        e = '0;
        e[31:0]    = 32'(sz_new);
        e[92:32]   = chain ? host_ent[int'(cnt) - 1][63:3] : haddr + 61'(cnt);
        e[94]      = 1'b0;
        e[106:95]  = idx;
        e[107]     = !half;
        e[117:108] = chain ? 10'd512 : desc - 10'(cnt);
        e[123:118] = bad ? 6'd1 : 6'd0;
        e[127:124] = 4'(dcnt);
        ef = {3'b000, !half, idx};
        exp_cnt      = int'(cnt);
        exp_dma_addr = {haddr, 3'b000};
        seen0        = dma_seen;

        w = '0;
        w[31:0] = size; w[92:32] = haddr; w[106:95] = idx; w[107] = half;
        w[117:108] = desc; w[123:118] = err_in; w[127:124] = 4'd3;
        @(negedge clk);
        req_tvalid = 1'b1;
        req_tdata  = w;
        while (!req_tready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_tvalid = poke;
        req_tdata  = ~w;
        repeat (3) @(negedge clk);
        req_tvalid = 1'b0;
        while (!fill_tvalid) @(negedge clk);
        chk(fill_tdata == ef, "R3", {name, " fill descriptor"}, 128'(fill_tdata), 128'(ef));
        chk(info_tdata[31:0] == e[31:0], "R7", {name, " size left"}, 128'(info_tdata[31:0]), 128'(e[31:0]));
        chk(info_tdata[92:32] == e[92:32], chain ? "R6" : "R8", {name, " next host addr"},
            128'(info_tdata[92:32]), 128'(e[92:32]));
        chk(info_tdata[117:108] == e[117:108], chain ? "R6" : "R8", {name, " descriptors left"},
            128'(info_tdata[117:108]), 128'(e[117:108]));
        chk(info_tdata[123:118] == e[123:118], "R10", {name, " error code"},
            128'(info_tdata[123:118]), 128'(e[123:118]));
        chk(info_tdata == e, "R9", {name, " whole word"}, info_tdata, e);
        repeat (stall) @(negedge clk);
        fill_tready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fill_tready = 1'b0;
        chk(wr_addr_q.size() == 0, "R5", {name, " writes outstanding"}, 128'(wr_addr_q.size()), 128'(0));
        chk((dma_seen - seen0) == (cnt > 0 ? 1 : 0), "R11", {name, " DMA request count"},
            128'(dma_seen - seen0), 128'(cnt > 0 ? 1 : 0));
        wr_addr_q.delete();
        wr_data_q.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) host_ent[k] = 64'h0010_0000 + 64'(k) * 64'h1000;
        repeat (3) @(negedge clk);
        chk(req_tready == 1'b1, "R1", "reset tready", 128'(req_tready), 128'(1));
        chk(fill_tvalid == 1'b0, "R1", "reset fill_tvalid", 128'(fill_tvalid), 128'(0));
        chk(dma_req_valid == 1'b0, "R1", "reset dma_req_valid", 128'(dma_req_valid), 128'(0));
        chk(mem_we == 1'b0, "R1", "reset mem_we", 128'(mem_we), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R8: short fetch, ping to pong
        run_txn("basic", 32'h3000, 61'h2000, 10'd20, 12'd5, 1'b0, 6'd0, 2, 1'b1);
        // R6: chain, pong to ping
        host_ent[7] = 64'h0000_0000_0077_8000;
        run_txn("chain", 32'd20 * 32'd4096, 61'h3000, 10'd30, 12'd5, 1'b1, 6'd0, 0, 1'b0);
        // R7: size not page multiple, highest index
        run_txn("partial", 32'd5000, 61'h4000, 10'd5, 12'hFFF, 1'b0, 6'd0, 1, 1'b0);
        // R10: data entry with page offset, incoming error ignored
        host_ent[1] = 64'h0010_1200;
        run_txn("dataoff", 32'h2000, 61'h5000, 10'd10, 12'd9, 1'b1, 6'h3F, 0, 1'b1);
        host_ent[1] = 64'h0010_1000;
        // R10: chain pointer not qword aligned
        host_ent[7] = 64'h0000_0000_0088_0002;
        run_txn("ptrbad", 32'd9 * 32'd4096, 61'h6000, 10'd9, 12'd3, 1'b0, 6'd0, 0, 1'b0);
        // R8: descriptor-limited fetch, incoming error cleared
        run_txn("desclim", 32'd10 * 32'd4096, 61'h7000, 10'd4, 12'd2, 1'b0, 6'd5, 0, 1'b0);
        // R11: zero-size request
        run_txn("empty", 32'd0, 61'h8000, 10'd7, 12'd1, 1'b1, 6'd0, 1, 1'b0);
        // R6: need equals N exactly; pointer offset only qword aligned is legal
        host_ent[7] = 64'h0000_0000_0077_8040;
        run_txn("exact", 32'd8 * 32'd4096, 61'h9000, 10'd100, 12'd7, 1'b0, 6'd0, 3, 1'b1);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule